// File: doc/BRIEF.md
# Key-Unlocked Indexed Configuration Port

This block holds the configuration register space of a multi-function peripheral controller. A host reaches it through two byte addresses on an I/O bus. Until a specific unlock byte is written, the register space stays hidden: writes have no effect and reads return all ones. Once the space is unlocked, the host writes an index byte to the first address. It then reads or writes the selected register through the second address. A separate lock byte hides the space again.

A small set of registers is shared by all devices: a logical device selector, a fixed identity code and a revision code. The remaining registers are banked, with one full copy per logical device. The current selector value decides which copy a data access reaches. Each bank holds an activate flag, a primary and a secondary 16-bit base address, two interrupt selects and two address-decoder control bytes. One bank number also exposes a row of GPIO configuration bytes. The activate flags, base addresses, interrupt selects and GPIO settings are driven out as flat vectors, so the peripheral functions beside this block can pick them up.

Top module: `cfgport_ctl`

## Requirements
- R1: After reset the block is locked, the index and selector are 0, every bank register and GPIO byte is 0, and all outputs are 0.
- R2: While locked, writing 0x55 to the base address unlocks the space from the next cycle.
- R3: While locked, every other write to either address is ignored, and reads from either address return 0xFF. Outside an active read (rd_en low, or an address other than the two port addresses), rdata is 0xFF.
- R4: While unlocked, writing 0xAA to the base address locks the space. Any other byte written there becomes the index, and a read at the base address returns the index.
- R5: A read at base+1 returns the register chosen by the index. Index 0x20 reads 0x30 and index 0x21 reads 0x01. Writes to these two indices change nothing.
- R6: Index 0x07 is the read/write logical device selector. For selector values of NDEV (9) or above, banked writes are ignored and banked reads return 0x00.
- R7: Index 0x30 is the banked activate register. Only bit 0 is stored, it reads back as {7'b0, bit0}, and it drives dev_active[selector].
- R8: Indices 0x60 and 0x61 hold the high and low bytes of the primary base address. Indices 0x62 and 0x63 hold the secondary base address. Each appears on the 16-bit slice of its device in dev_pri_base or dev_sec_base.
- R9: Index 0x70 (primary interrupt select), index 0x72 (secondary interrupt select), and indices 0xF0 and 0xF1 (decoder control) are banked read/write bytes. The interrupt selects drive dev_pri_irq and dev_sec_irq.
- R10: Each bank is independent. A write under one selector value never changes the registers or outputs of another device.
- R11: When the selector is 8, indices 0xC0..0xC7 hold the GPIO configuration bytes. In each byte, bit 0 is direction (1 = input), bit 1 is invert, bit 2 is combined-interrupt enable and bits 4:3 are function select. Bits 7:5 read as 0. GPIO byte n drives gpio_cfg[5n+4:5n]. Under any other selector these indices behave as unmapped.
- R12: Unmapped indices read 0x00 while unlocked, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 16 | Host I/O address |
| wr_en | input | 1 | Host write strobe, one write per cycle |
| rd_en | input | 1 | Host read strobe |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Host read byte (combinational) |
| dev_active | output | 9 | Activate flag per logical device |
| dev_pri_base | output | 144 | Primary base address, 16 bits per device |
| dev_sec_base | output | 144 | Secondary base address, 16 bits per device |
| dev_pri_irq | output | 72 | Primary interrupt select, 8 bits per device |
| dev_sec_irq | output | 72 | Secondary interrupt select, 8 bits per device |
| gpio_cfg | output | 40 | GPIO configuration, 5 bits per GPIO byte |

## Verification
Several behaviours are checked by assertions on every cycle:
- the unlock and lock keys taking effect one cycle later;
- the locked state never changing an output and always reading 0xFF;
- the identity code holding at index 0x20;
- the banked outputs staying put on any cycle without a data write.

Other behaviours can only be shown by the bench's scenarios, where a behavioural register map is compared with every output each clock:
- the banking itself, including isolation between devices;
- the out-of-range selector;
- the masking of the activate bit and of the GPIO bytes;
- GPIO indices falling back to unmapped in ordinary banks.

// File: rtl/cfgport_ctl.sv
module cfgport_ctl #(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0,
  parameter int              NDEV      = 9,
  parameter int              AUX_LDN   = 8,
  parameter int              NGPIO     = 8,
  parameter logic [7:0]      GPIO_IDX  = 8'hC0,
  parameter logic [7:0]      ENTER_KEY = 8'h55,
  parameter logic [7:0]      EXIT_KEY  = 8'hAA,
  parameter logic [7:0]      DEV_ID    = 8'h30,
  parameter logic [7:0]      DEV_REV   = 8'h01
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [7:0]          wdata,
  output logic [7:0]          rdata,
  output logic [NDEV-1:0]     dev_active,
  output logic [NDEV*16-1:0]  dev_pri_base,
  output logic [NDEV*16-1:0]  dev_sec_base,
  output logic [NDEV*8-1:0]   dev_pri_irq,
  output logic [NDEV*8-1:0]   dev_sec_irq,
  output logic [NGPIO*5-1:0]  gpio_cfg
);
  localparam int SW = (NDEV > 1) ? $clog2(NDEV) : 1;
  localparam int GW = (NGPIO > 1) ? $clog2(NGPIO) : 1;
  localparam logic [ADDR_W-1:0] DAT_ADDR = BASE_ADDR + 1'b1;
  localparam logic [7:0] NDEV_B  = 8'(NDEV);
  localparam logic [7:0] NGPIO_B = 8'(NGPIO);
  localparam logic [7:0] AUX_B   = 8'(AUX_LDN);

  localparam logic [7:0] IX_LDN  = 8'h07;
  localparam logic [7:0] IX_ID   = 8'h20;
  localparam logic [7:0] IX_REV  = 8'h21;
  localparam logic [7:0] IX_ACT  = 8'h30;
  localparam logic [7:0] IX_PBH  = 8'h60;
  localparam logic [7:0] IX_PBL  = 8'h61;
  localparam logic [7:0] IX_SBH  = 8'h62;
  localparam logic [7:0] IX_SBL  = 8'h63;
  localparam logic [7:0] IX_PIRQ = 8'h70;
  localparam logic [7:0] IX_SIRQ = 8'h72;
  localparam logic [7:0] IX_DEC0 = 8'hF0;
  localparam logic [7:0] IX_DEC1 = 8'hF1;

  logic        cfg_mode;
  logic [7:0]  idx, ldn;
  logic        act   [NDEV];
  logic [15:0] pbase [NDEV];
  logic [15:0] sbase [NDEV];
  logic [7:0]  pirq  [NDEV];
  logic [7:0]  sirq  [NDEV];
  logic [7:0]  dec0  [NDEV];
  logic [7:0]  dec1  [NDEV];
  logic [4:0]  gcfg  [NGPIO];

  wire hit_idx = addr == BASE_ADDR;
  wire hit_dat = addr == DAT_ADDR;
  wire idx_wr  = cfg_mode && wr_en && hit_idx;
  wire dat_wr  = cfg_mode && wr_en && hit_dat;
  wire ldn_ok  = ldn < NDEV_B;
  wire [SW-1:0] sel = ldn[SW-1:0];
  wire [7:0] goff    = idx - GPIO_IDX;
  wire       gpio_ok = (ldn == AUX_B) && (goff < NGPIO_B);
  wire [GW-1:0] gsel = goff[GW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_mode <= 1'b0;
      idx      <= 8'h00;
      ldn      <= 8'h00;
    end else begin
      if (!cfg_mode) begin
        if (wr_en && hit_idx && wdata == ENTER_KEY) cfg_mode <= 1'b1;
      end else if (idx_wr) begin
        if (wdata == EXIT_KEY) cfg_mode <= 1'b0;
        else                   idx      <= wdata;
      end
      if (dat_wr && idx == IX_LDN) ldn <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int d = 0; d < NDEV; d++) begin
        act[d]   <= 1'b0;
        pbase[d] <= 16'h0000;
        sbase[d] <= 16'h0000;
        pirq[d]  <= 8'h00;
        sirq[d]  <= 8'h00;
        dec0[d]  <= 8'h00;
        dec1[d]  <= 8'h00;
      end
      for (int g = 0; g < NGPIO; g++) gcfg[g] <= 5'h00;
    end else if (dat_wr) begin
      if (gpio_ok) gcfg[gsel] <= wdata[4:0];
      else if (ldn_ok) begin
        case (idx)
          IX_ACT:  act[sel]         <= wdata[0];
          IX_PBH:  pbase[sel][15:8] <= wdata;
          IX_PBL:  pbase[sel][7:0]  <= wdata;
          IX_SBH:  sbase[sel][15:8] <= wdata;
          IX_SBL:  sbase[sel][7:0]  <= wdata;
          IX_PIRQ: pirq[sel]        <= wdata;
          IX_SIRQ: sirq[sel]        <= wdata;
          IX_DEC0: dec0[sel]        <= wdata;
          IX_DEC1: dec1[sel]        <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = 8'hFF;
    if (cfg_mode && rd_en) begin
      if (hit_idx) rdata = idx;
      else if (hit_dat) begin
        rdata = 8'h00;
        if      (idx == IX_LDN) rdata = ldn;
        else if (idx == IX_ID)  rdata = DEV_ID;
        else if (idx == IX_REV) rdata = DEV_REV;
        else if (gpio_ok)       rdata = {3'b000, gcfg[gsel]};
        else if (ldn_ok) begin
          case (idx)
            IX_ACT:  rdata = {7'b0, act[sel]};
            IX_PBH:  rdata = pbase[sel][15:8];
            IX_PBL:  rdata = pbase[sel][7:0];
            IX_SBH:  rdata = sbase[sel][15:8];
            IX_SBL:  rdata = sbase[sel][7:0];
            IX_PIRQ: rdata = pirq[sel];
            IX_SIRQ: rdata = sirq[sel];
            IX_DEC0: rdata = dec0[sel];
            IX_DEC1: rdata = dec1[sel];
            default: rdata = 8'h00;
          endcase
        end
      end
    end
  end

  for (genvar d = 0; d < NDEV; d++) begin : g_dev
    assign dev_active[d]           = act[d];
    assign dev_pri_base[d*16 +: 16] = pbase[d];
    assign dev_sec_base[d*16 +: 16] = sbase[d];
    assign dev_pri_irq[d*8 +: 8]    = pirq[d];
    assign dev_sec_irq[d*8 +: 8]    = sirq[d];
  end

  for (genvar g = 0; g < NGPIO; g++) begin : g_gpio
    assign gpio_cfg[g*5 +: 5] = gcfg[g];
  end
endmodule

// File: rtl/cfgport_ctl_chk.sv
module cfgport_ctl_chk #(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0,
  parameter int              NDEV      = 9,
  parameter int              NGPIO     = 8,
  parameter logic [7:0]      ENTER_KEY = 8'h55,
  parameter logic [7:0]      EXIT_KEY  = 8'hAA,
  parameter logic [7:0]      DEV_ID    = 8'h30
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  addr,
  input logic               wr_en,
  input logic               rd_en,
  input logic [7:0]         wdata,
  input logic [7:0]         rdata,
  input logic               cfg_mode,
  input logic [7:0]         idx,
  input logic [NDEV-1:0]    dev_active,
  input logic [NDEV*16-1:0] dev_pri_base,
  input logic [NDEV*16-1:0] dev_sec_base,
  input logic [NDEV*8-1:0]  dev_pri_irq,
  input logic [NGPIO*5-1:0] gpio_cfg
);
  localparam logic [ADDR_W-1:0] DAT_ADDR = BASE_ADDR + 1'b1;
  wire enter = !cfg_mode && wr_en && addr == BASE_ADDR && wdata == ENTER_KEY;

  AST_ENTER_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    enter |=> cfg_mode); // R2
  AST_EXIT_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode && wr_en && addr == BASE_ADDR && wdata == EXIT_KEY |=> !cfg_mode); // R4
  AST_LOCKED_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode && !enter |=> !cfg_mode && $stable(dev_active) && $stable(dev_pri_base)
      && $stable(dev_sec_base) && $stable(dev_pri_irq) && $stable(gpio_cfg)); // R3
  AST_LOCKED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode && rd_en |-> rdata == 8'hFF); // R3
  AST_ID_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode && rd_en && addr == DAT_ADDR && idx == 8'h20 |-> rdata == DEV_ID); // R5
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == DAT_ADDR) |=> $stable(dev_active) && $stable(dev_pri_base)
      && $stable(dev_sec_base) && $stable(gpio_cfg)); // R10
endmodule

bind cfgport_ctl cfgport_ctl_chk #(
  .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NDEV(NDEV), .NGPIO(NGPIO),
  .ENTER_KEY(ENTER_KEY), .EXIT_KEY(EXIT_KEY), .DEV_ID(DEV_ID)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .rdata(rdata), .cfg_mode(cfg_mode), .idx(idx),
  .dev_active(dev_active), .dev_pri_base(dev_pri_base), .dev_sec_base(dev_sec_base),
  .dev_pri_irq(dev_pri_irq), .gpio_cfg(gpio_cfg)
);

// File: tb/cfgport_ctl_bench.sv
module cfgport_ctl_bench;
  localparam logic [15:0] BASE = 16'h03F0;
  localparam logic [15:0] DATA = 16'h03F1;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic [8:0]   dev_active;
  logic [143:0] dev_pri_base, dev_sec_base;
  logic [71:0]  dev_pri_irq, dev_sec_irq;
  logic [39:0]  gpio_cfg;

  always #5 clk = ~clk;

  cfgport_ctl u_cfgport_ctl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .dev_active(dev_active),
    .dev_pri_base(dev_pri_base), .dev_sec_base(dev_sec_base),
    .dev_pri_irq(dev_pri_irq), .dev_sec_irq(dev_sec_irq), .gpio_cfg(gpio_cfg)
  );

  int checks = 0, failures = 0;
  string cur_req = "R1";

  bit m_cfg;
  int m_idx, m_ldn;
  int m_reg[int];

  function automatic int get(int dev, int ix);
    return m_reg.exists(dev*256 + ix) ? m_reg[dev*256 + ix] : 0;
  endfunction

  function automatic bit banked(int ix);
    return ix == 'h30 || (ix >= 'h60 && ix <= 'h63) || ix == 'h70 || ix == 'h72
        || ix == 'hF0 || ix == 'hF1;
  endfunction

  function automatic bit is_gpio(int ix);
    return m_ldn == 8 && ix >= 'hC0 && ix <= 'hC7;
  endfunction

  function automatic logic [7:0] exp_read(logic [15:0] a, logic r);
    if (!r || !m_cfg) return 8'hFF;
    if (a == BASE) return 8'(m_idx);
    if (a != DATA) return 8'hFF;
    if (m_idx == 'h07) return 8'(m_ldn);
    if (m_idx == 'h20) return 8'h30;
    if (m_idx == 'h21) return 8'h01;
    if (is_gpio(m_idx)) return 8'(get(8, m_idx) & 'h1F);
    if (m_ldn < 9 && banked(m_idx)) return 8'(get(m_ldn, m_idx));
    return 8'h00;
  endfunction

  function automatic void model_write(logic [15:0] a, logic [7:0] d);
    if (!m_cfg) begin
      if (a == BASE && d == 8'h55) m_cfg = 1'b1;
    end else if (a == BASE) begin
      if (d == 8'hAA) m_cfg = 1'b0; else m_idx = int'(d);
    end else if (a == DATA) begin
      if (m_idx == 'h07) m_ldn = int'(d);
      else if (is_gpio(m_idx)) m_reg[8*256 + m_idx] = int'(d) & 'h1F;
      else if (m_ldn < 9 && banked(m_idx))
        m_reg[m_ldn*256 + m_idx] = (m_idx == 'h30) ? (int'(d) & 1) : int'(d);
    end
  endfunction

  task automatic chk(bit ok, string what, string act, string exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%s expected=%s", cur_req, what, act, exp);
    end
  endtask

  task automatic compare_all(logic [15:0] a, logic r);
    logic [8:0] e_act;
    logic [143:0] e_pb, e_sb;
    logic [71:0] e_pi, e_si;
    logic [39:0] e_g;
    logic [7:0] e_r;
    for (int d = 0; d < 9; d++) begin
      e_act[d] = 1'(get(d, 'h30));
      e_pb[d*16 +: 16] = 16'((get(d, 'h60) << 8) | get(d, 'h61));
      e_sb[d*16 +: 16] = 16'((get(d, 'h62) << 8) | get(d, 'h63));
      e_pi[d*8 +: 8] = 8'(get(d, 'h70));
      e_si[d*8 +: 8] = 8'(get(d, 'h72));
    end
    for (int g = 0; g < 8; g++) e_g[g*5 +: 5] = 5'(get(8, 'hC0 + g));
    e_r = exp_read(a, r);
    chk(rdata === e_r, "rdata", $sformatf("%h", rdata), $sformatf("%h", e_r));
    chk(dev_active === e_act, "dev_active", $sformatf("%h", dev_active), $sformatf("%h", e_act));
    chk(dev_pri_base === e_pb, "dev_pri_base", $sformatf("%h", dev_pri_base), $sformatf("%h", e_pb));
    chk(dev_sec_base === e_sb, "dev_sec_base", $sformatf("%h", dev_sec_base), $sformatf("%h", e_sb));
    chk(dev_pri_irq === e_pi, "dev_pri_irq", $sformatf("%h", dev_pri_irq), $sformatf("%h", e_pi));
    chk(dev_sec_irq === e_si, "dev_sec_irq", $sformatf("%h", dev_sec_irq), $sformatf("%h", e_si));
    chk(gpio_cfg === e_g, "gpio_cfg", $sformatf("%h", gpio_cfg), $sformatf("%h", e_g));
  endtask

  task automatic cyc(logic w, logic r, logic [15:0] a, logic [7:0] d);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    #1 compare_all(a, r);
    @(posedge clk);
    #1;
    if (!rst_n) begin
      m_cfg = 1'b0; m_idx = 0; m_ldn = 0; m_reg.delete();
    end else if (w) model_write(a, d);
    @(negedge clk);
  endtask

  task automatic wr_reg(logic [7:0] ix, logic [7:0] v);
    cyc(1, 0, BASE, ix);
    cyc(1, 0, DATA, v);
  endtask

  task automatic rd_reg(logic [7:0] ix);
    cyc(1, 0, BASE, ix);
    cyc(0, 1, DATA, 8'h00);
    cyc(0, 1, BASE, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired in %s", cur_req);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    m_cfg = 1'b0; m_idx = 0; m_ldn = 0;
    @(negedge clk);
    cur_req = "R1";
    repeat (3) cyc(0, 0, BASE, 8'h00);
    rst_n = 1'b1;
    cyc(0, 1, BASE, 8'h00);
    cyc(0, 1, DATA, 8'h00);

    cur_req = "R3";
    cyc(1, 0, DATA, 8'h55);
    cyc(1, 0, BASE, 8'h07);
    cyc(1, 0, DATA, 8'h04);
    cyc(1, 0, BASE, 8'hAA);
    cyc(1, 0, 16'h03F2, 8'h55);
    cyc(0, 1, BASE, 8'h00);
    cyc(0, 1, DATA, 8'h00);

    cur_req = "R2";
    cyc(1, 0, BASE, 8'h55);
    cyc(0, 1, BASE, 8'h00);

    cur_req = "R5";
    rd_reg(8'h20);
    rd_reg(8'h21);
    wr_reg(8'h20, 8'h99);
    rd_reg(8'h20);
    cyc(0, 1, 16'h03F2, 8'h00);

    cur_req = "R4";
    cyc(1, 0, BASE, 8'h61);
    cyc(0, 1, BASE, 8'h00);
    cyc(1, 0, BASE, 8'h55);
    cyc(0, 1, BASE, 8'h00);

    cur_req = "R7";
    wr_reg(8'h07, 8'h04);
    wr_reg(8'h30, 8'hFF);
    rd_reg(8'h30);
    wr_reg(8'h30, 8'hFE);
    rd_reg(8'h30);
    wr_reg(8'h30, 8'h01);

    cur_req = "R8";
    wr_reg(8'h60, 8'h03);
    wr_reg(8'h61, 8'hF8);
    wr_reg(8'h62, 8'h12);
    wr_reg(8'h63, 8'h34);
    rd_reg(8'h61);
    rd_reg(8'h62);

    cur_req = "R9";
    wr_reg(8'h70, 8'h04);
    wr_reg(8'h72, 8'h0C);
    wr_reg(8'hF0, 8'h0C);
    wr_reg(8'hF1, 8'h5A);
    rd_reg(8'h70);
    rd_reg(8'h72);
    rd_reg(8'hF0);
    rd_reg(8'hF1);

    cur_req = "R10";
    wr_reg(8'h07, 8'h05);
    rd_reg(8'h61);
    wr_reg(8'h30, 8'h01);
    wr_reg(8'h60, 8'h02);
    wr_reg(8'h61, 8'hF8);
    wr_reg(8'h70, 8'h03);
    wr_reg(8'h07, 8'h01);
    wr_reg(8'h60, 8'h01);
    wr_reg(8'h61, 8'hF0);
    wr_reg(8'h62, 8'h03);
    wr_reg(8'h63, 8'hF6);
    wr_reg(8'h07, 8'h04);
    rd_reg(8'h60);
    rd_reg(8'h70);

    cur_req = "R6";
    rd_reg(8'h07);
    wr_reg(8'h07, 8'h0C);
    rd_reg(8'h07);
    wr_reg(8'h30, 8'h01);
    wr_reg(8'h60, 8'hAB);
    rd_reg(8'h30);
    rd_reg(8'h60);
    wr_reg(8'h07, 8'h09);
    wr_reg(8'h70, 8'h07);
    rd_reg(8'h70);

    cur_req = "R11";
    wr_reg(8'h07, 8'h08);
    for (int g = 0; g < 8; g++) wr_reg(8'hC0 + 8'(g), 8'(g * 37 + 1));
    wr_reg(8'hC5, 8'hFF);
    rd_reg(8'hC5);
    rd_reg(8'hC0);
    rd_reg(8'hC8);
    wr_reg(8'h30, 8'h01);
    wr_reg(8'h07, 8'h04);
    rd_reg(8'hC5);
    wr_reg(8'hC2, 8'h1F);
    rd_reg(8'hC2);

    cur_req = "R12";
    wr_reg(8'h44, 8'h77);
    rd_reg(8'h44);
    wr_reg(8'h71, 8'h66);
    rd_reg(8'h71);

    cur_req = "R4";
    cyc(1, 0, BASE, 8'hAA);
    cyc(0, 1, BASE, 8'h00);
    cur_req = "R3";
    cyc(1, 0, DATA, 8'h00);
    cyc(1, 0, BASE, 8'h30);
    cyc(1, 0, DATA, 8'h00);
    cyc(0, 1, DATA, 8'h00);
    cur_req = "R2";
    cyc(1, 0, BASE, 8'h55);
    rd_reg(8'h07);
    rd_reg(8'h30);

    cur_req = "R1";
    rst_n = 1'b0;
    cyc(0, 0, BASE, 8'h00);
    cyc(0, 0, BASE, 8'h00);
    rst_n = 1'b1;
    cyc(0, 1, BASE, 8'h00);
    cyc(1, 0, BASE, 8'h55);
    rd_reg(8'h07);
    rd_reg(8'h60);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule